// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block connects two 16-bit buses, side A and side B. It is split into two independent 8-bit halves. Each half either moves data straight across from one side to the other or drives the outgoing side from a capture register that was loaded earlier. Each bidirectional pin is modelled as three signals: an input vector, an output vector and a per-bit output-enable vector. The pad ring resolves these into real pins.

Each half has its own isolate control, direction control, two source selects and two capture strobes. The capture strobes are enables sampled in one shared clock domain. The A-side register loads from the A input, and the B-side register loads from the B input. This happens on any clock edge where the matching strobe is high, including while the half is isolated.

The block carries no data stream with flow control. Every pin is a plain control or data pin, so back-pressure does not apply. The source selects and the capture registers provide the holding function that a stream interface would otherwise need.

Top module: `xcvr_top`

## Requirements
- R1: The two 8-bit halves are independent. Half 0 uses bits 7:0 and control bit 0; half 1 uses bits 15:8 and control bit 1. No control of one half affects the outputs of the other.
- R2: When `cap_a` of a half is high at a clock edge, that half's A register loads its slice of `a_in`. When `cap_a` is low, the register keeps its value even if `a_in` changes.
- R3: When `cap_b` of a half is high at a clock edge, that half's B register loads its slice of `b_in`. When `cap_b` is low, the register keeps its value.
- R4: When `iso` of a half is 1, that half's bits of `a_oe` and `b_oe` are all 0. Captures (R2, R3) still take place.
- R5: When `iso` is 0 and `dir` is 0, the half's `a_oe` bits are all 1 and its `b_oe` bits are all 0 (B side drives A).
- R6: When `iso` is 0 and `dir` is 1, the half's `b_oe` bits are all 1 and its `a_oe` bits are all 0 (A side drives B).
- R7: `b_out` follows the same-cycle `a_in` when `sel_ab` is 0, and follows the stored A register when `sel_ab` is 1. This does not depend on `iso` or `dir`.
- R8: `a_out` follows the same-cycle `b_in` when `sel_ba` is 0, and follows the stored B register when `sel_ba` is 1.
- R9: While `rst_n` is low at a clock edge, both registers of both halves are cleared to zero.
- R10: Within a half, the A and B enables are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset of the capture registers |
| iso | input | 2 | Per half: 1 isolates both sides |
| dir | input | 2 | Per half: 1 drives B from A, 0 drives A from B |
| sel_ab | input | 2 | Per half: source for B output, 0 live A, 1 stored A |
| sel_ba | input | 2 | Per half: source for A output, 0 live B, 1 stored B |
| cap_a | input | 2 | Per half: capture strobe for the A register |
| cap_b | input | 2 | Per half: capture strobe for the B register |
| a_in | input | 16 | Value seen on the A pins |
| a_out | output | 16 | Value offered to the A pins |
| a_oe | output | 16 | Per-bit drive enable for the A pins |
| b_in | input | 16 | Value seen on the B pins |
| b_out | output | 16 | Value offered to the B pins |
| b_oe | output | 16 | Per-bit drive enable for the B pins |

## Verification
The enables and the live-data outputs respond in the same cycle, with no register in the path. A stored value becomes visible one clock edge after its strobe. The bench drives inputs just after the falling edge and checks every output 1 ns later. It updates its register model only at the rising edge, using the inputs that were held at that edge. Each check therefore compares against the register state of the previous edge plus the live inputs of the current cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned HALF_W_DEF = 8;
  localparam int unsigned N_HALF_DEF = 2;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= din;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_e         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out
);
  always_comb begin
    unique case (sel)
      SRC_STORED: out = stored;
      default:    out = live;
    endcase
  end
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         iso,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe
);
  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  logic         drive_a;
  logic         drive_b;

  xcvr_store #(.W(W)) u_store_a (
    .clk(clk), .rst_n(rst_n), .cap(cap_a), .din(a_in), .q(reg_a)
  );
  xcvr_store #(.W(W)) u_store_b (
    .clk(clk), .rst_n(rst_n), .cap(cap_b), .din(b_in), .q(reg_b)
  );

  xcvr_path #(.W(W)) u_to_b (
    .sel(src_e'(sel_ab)), .live(a_in), .stored(reg_a), .out(b_out)
  );
  xcvr_path #(.W(W)) u_to_a (
    .sel(src_e'(sel_ba)), .live(b_in), .stored(reg_b), .out(a_out)
  );

  always_comb begin
    drive_a = !iso && !dir;
    drive_b = !iso && dir;
    a_oe    = {W{drive_a}};
    b_oe    = {W{drive_b}};
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe))); // R10
  AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    iso |-> (a_oe == '0 && b_oe == '0)); // R4
  AST_DRIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!iso && !dir) |-> (&a_oe && b_oe == '0)); // R5
  AST_DRIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!iso && dir) |-> (&b_oe && a_oe == '0)); // R6
  AST_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> reg_a == $past(a_in)); // R2
  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_a |=> $stable(reg_a)); // R2
  AST_B_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_b |=> reg_b == $past(b_in)); // R3
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_b |=> $stable(reg_b)); // R3
  AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ab |-> b_out == a_in); // R7
  AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ba |-> a_out == b_in); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (reg_a == '0 && reg_b == '0)); // R9
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top
  import xcvr_pkg::*;
#(
  parameter int unsigned HALF_W = HALF_W_DEF,
  parameter int unsigned N_HALF = N_HALF_DEF,
  localparam int unsigned BUS_W = HALF_W * N_HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HALF-1:0] iso,
  input  logic [N_HALF-1:0] dir,
  input  logic [N_HALF-1:0] sel_ab,
  input  logic [N_HALF-1:0] sel_ba,
  input  logic [N_HALF-1:0] cap_a,
  input  logic [N_HALF-1:0] cap_b,
  input  logic [BUS_W-1:0]  a_in,
  output logic [BUS_W-1:0]  a_out,
  output logic [BUS_W-1:0]  a_oe,
  input  logic [BUS_W-1:0]  b_in,
  output logic [BUS_W-1:0]  b_out,
  output logic [BUS_W-1:0]  b_oe
);
  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    xcvr_half #(.W(HALF_W)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .iso   (iso[h]),
      .dir   (dir[h]),
      .sel_ab(sel_ab[h]),
      .sel_ba(sel_ba[h]),
      .cap_a (cap_a[h]),
      .cap_b (cap_b[h]),
      .a_in  (a_in[h*HALF_W +: HALF_W]),
      .b_in  (b_in[h*HALF_W +: HALF_W]),
      .a_out (a_out[h*HALF_W +: HALF_W]),
      .b_out (b_out[h*HALF_W +: HALF_W]),
      .a_oe  (a_oe[h*HALF_W +: HALF_W]),
      .b_oe  (b_oe[h*HALF_W +: HALF_W])
    );
  end
endmodule

// File: tb/tb_xcvr_top.sv
`timescale 1ns/1ps
module tb_xcvr_top;
  localparam int W  = 8;
  localparam int NH = 2;
  localparam int BW = W * NH;

  logic clk = 1'b0;
  logic rst_n;
  logic [NH-1:0] iso, dir, sel_ab, sel_ba, cap_a, cap_b;
  logic [BW-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] ma [NH];
  logic [W-1:0] mb [NH];

  always #2 clk = ~clk;

  xcvr_top dut (
    .clk(clk), .rst_n(rst_n), .iso(iso), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in),
    .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] exp_a_out();
    logic [BW-1:0] r;
    for (int h = 0; h < NH; h++)
      r[h*W +: W] = sel_ba[h] ? mb[h] : b_in[h*W +: W];
    return r;
  endfunction

  function automatic logic [BW-1:0] exp_b_out();
    logic [BW-1:0] r;
    for (int h = 0; h < NH; h++)
      r[h*W +: W] = sel_ab[h] ? ma[h] : a_in[h*W +: W];
    return r;
  endfunction

  function automatic logic [BW-1:0] exp_oe(input bit want_dir);
    logic [BW-1:0] r;
    for (int h = 0; h < NH; h++)
      r[h*W +: W] = (!iso[h] && (dir[h] == want_dir)) ? {W{1'b1}} : {W{1'b0}};
    return r;
  endfunction

  task automatic check_all();
    #1;
    chk("R8 a_out source", a_out, exp_a_out());
    chk("R7 b_out source", b_out, exp_b_out());
    chk("R1 R4 R5 a_oe", a_oe, exp_oe(1'b0));
    chk("R1 R4 R6 b_oe", b_oe, exp_oe(1'b1));
    chk("R10 no contention", a_oe & b_oe, '0);
  endtask

  task automatic step();
    @(posedge clk);
    for (int h = 0; h < NH; h++) begin
      if (!rst_n) begin
        ma[h] = '0;
        mb[h] = '0;
      end else begin
        if (cap_a[h]) ma[h] = a_in[h*W +: W];
        if (cap_b[h]) mb[h] = b_in[h*W +: W];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int h = 0; h < NH; h++) begin ma[h] = 'x; mb[h] = 'x; end
    rst_n = 1'b0; iso = '1; dir = '0; sel_ab = '1; sel_ba = '1;
    cap_a = '0; cap_b = '0; a_in = 16'h1234; b_in = 16'h5678;
    @(negedge clk);
    step(); step();
    rst_n = 1'b1;
    check_all();
    chk("R9 reset clears A regs", b_out, '0);
    chk("R9 reset clears B regs", a_out, '0);

    for (int h = 0; h < NH; h++) begin
      iso = '0; dir = '1; sel_ab = '0; sel_ba = '0;
      cap_a = '0; cap_a[h] = 1'b1;
      a_in = {NH{8'hA5}};
      check_all();
      step();
      cap_a = '0; sel_ab[h] = 1'b1; a_in = {NH{8'h3C}};
      check_all();
      chk("R2 stored A held", {8'h0, b_out[h*W +: W]}, {8'h0, 8'hA5});

      iso = '0; iso[h] = 1'b1; dir = '0; sel_ba = '0;
      cap_b = '0; cap_b[h] = 1'b1; b_in = {NH{8'h5E}};
      check_all();
      chk("R4 isolated enables", {8'h0, a_oe[h*W +: W] | b_oe[h*W +: W]}, '0);
      step();
      cap_b = '0; iso = '0; dir = '0; sel_ba[h] = 1'b1; b_in = {NH{8'hC3}};
      check_all();
      chk("R3 isolation capture driven", {8'h0, a_out[h*W +: W]}, {8'h0, 8'h5E});
      chk("R5 drive A after isolation", {8'h0, a_oe[h*W +: W]}, {8'h0, 8'hFF});
      step();
    end

    iso = 2'b01; dir = 2'b10;
    check_all();
    chk("R1 half1 drives while half0 isolated", b_oe, 16'hFF00);

    for (int i = 0; i < 3000; i++) begin
      rst_n  = ($urandom_range(0, 199) != 0);
      iso    = NH'($urandom); dir    = NH'($urandom);
      sel_ab = NH'($urandom); sel_ba = NH'($urandom);
      cap_a  = NH'($urandom); cap_b  = NH'($urandom);
      a_in   = BW'($urandom); b_in   = BW'($urandom);
      check_all();
      step();
    end
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule